// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets logic running on a single clock read and write an external 8K x 8 asynchronous static RAM. The RAM is selected by a pair of enables of opposite polarity, and it has an active-low read (output) strobe, an active-low write strobe and a shared 8-bit data bus. The bus is brought out as separate outbound data, drive-enable and inbound data signals, so the tristate pad can sit at the chip edge.

The host issues one transfer at a time. It raises `reqValid` together with the direction, a 13-bit address and, for a write, a data byte, and it holds them until `ack` pulses. Every RAM timing minimum is a nanosecond parameter. Each one is turned into a whole number of cycles, with a floor of one cycle, using the `CLK_PERIOD_NS` parameter. The sequencer then holds each strobe for that many cycles. Before its own bus driver turns on, it waits until the RAM can no longer be driving the bus.

Top module: `asram_seq_ctrl`

## Requirements
- R1: During and after reset, with no transfer in progress, the RAM is deselected (`memSelN`=1, `memSelP`=0), `memRdN`=1, `memWrN`=1, `dqOe`=0 and `ack`=0.
- R2: A read selects the RAM (`memSelN`=0, `memSelP`=1) with `memWrN`=1 and `memRdN`=0 for RD_CYC cycles. RD_CYC is the largest of the cycle counts for the 35 ns cycle, the 35 ns address access and the 15 ns read-strobe access, which is 9 at a 4 ns period. From an idle controller, `ack` is seen 10 clock cycles after `reqValid` is raised.
- R3: Read data is sampled from `dqIn` at the clock edge that ends the last access cycle. It appears on `rdData` in the same cycle as `ack` and is held until the next read.
- R4: A write keeps the RAM selected with `memRdN`=1 and `memWrN`=0 for WP_CYC cycles. WP_CYC is the largest of the counts for the 20 ns pulse, the 25 ns select-to-end time and the 15 ns data setup, which is 7 at 4 ns.
- R5: Write data is driven (`dqOe`=1) for the whole write pulse and for exactly one cycle after `memWrN` rises, and is then released. The selected span of a write covers at least the 35 ns write cycle.
- R6: `dqOe` is raised only after `memRdN` has been high for TURN_CYC consecutive cycles. TURN_CYC is the count for the larger of the 12 ns read-strobe release and the 15 ns write-strobe release, which is 4 at 4 ns. The controller never drives while the RAM may still drive.
- R7: `ack` is high for exactly one cycle per transfer, and no new transfer is accepted in the cycle that `ack` is high.
- R8: `memAddr`, and `dqOut` while driven, stay stable for as long as the RAM stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Transfer request, held until ack |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Transfer address |
| reqWdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Last byte read |
| memAddr | output | 13 | RAM address |
| memSelN | output | 1 | Active-low RAM select |
| memSelP | output | 1 | Active-high RAM select |
| memRdN | output | 1 | Active-low read (output-enable) strobe |
| memWrN | output | 1 | Active-low write strobe |
| dqOut | output | 8 | Outbound bus data |
| dqOe | output | 1 | Bus driver enable |
| dqIn | input | 8 | Inbound bus data |

## Verification
Writes followed by reads use the bytes 0xA5, 0x5A, 0x00 and 0xFF, which separate stuck data bits from swapped ones, and the two end addresses 0 and 8191, which separate missing address bits from aliasing. A write issued right after a read shows whether the bus turnaround wait is applied, and its longer latency shows that wait in the cycle count. Back-to-back transfers against a memory model that checks timing catch early sampling, short strobes, early or late bus release and contention. A request held through the `ack` cycle shows whether a second transfer starts by mistake.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef struct packed {
    logic load;     // latch host address and data
    logic capture;  // sample inbound bus into read register
    logic select;   // RAM selected
    logic oeLow;    // read strobe asserted
    logic weLow;    // write strobe asserted
    logic drive;    // controller drives the bus
  } strobe_t;

  function automatic int cyclesFor(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_RD_CYCLE    = 35,
  parameter int T_ADDR_ACC    = 35,
  parameter int T_OE_ACC      = 15,
  parameter int T_WR_CYCLE    = 35,
  parameter int T_WE_PULSE    = 20,
  parameter int T_SEL_TO_END  = 25,
  parameter int T_DATA_SETUP  = 15,
  parameter int T_OE_HZ       = 12,
  parameter int T_WE_HZ       = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output strobe_t strb,
  output logic    ack
);

  localparam int RD_CYC   = maxOf(cyclesFor(T_RD_CYCLE, CLK_PERIOD_NS),
                                  maxOf(cyclesFor(T_ADDR_ACC, CLK_PERIOD_NS),
                                        cyclesFor(T_OE_ACC, CLK_PERIOD_NS)));
  localparam int WP_CYC   = maxOf(cyclesFor(T_WE_PULSE, CLK_PERIOD_NS),
                                  maxOf(cyclesFor(T_SEL_TO_END, CLK_PERIOD_NS),
                                        cyclesFor(T_DATA_SETUP, CLK_PERIOD_NS)));
  localparam int REC_CYC  = maxOf(1, cyclesFor(T_WR_CYCLE, CLK_PERIOD_NS) - WP_CYC);
  localparam int TURN_CYC = maxOf(cyclesFor(T_OE_HZ, CLK_PERIOD_NS),
                                  cyclesFor(T_WE_HZ, CLK_PERIOD_NS));
  localparam int MAX_CYC  = maxOf(RD_CYC, maxOf(WP_CYC, REC_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int TURN_W   = $clog2(TURN_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WPULSE, ST_WREC} state_t;

  state_t             stateQ, stateD;
  logic [CNT_W-1:0]   cntQ, cntD;
  logic               ackQ, ackD;
  logic [TURN_W-1:0]  oeRunQ;
  logic               turnOk;

  assign turnOk = (oeRunQ == TURN_W'(TURN_CYC));
  assign ack    = ackQ;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    ackD   = 1'b0;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid && !ackQ && (!reqWrite || turnOk)) begin
          strb.load = 1'b1;
          cntD      = '0;
          stateD    = reqWrite ? ST_WPULSE : ST_READ;
        end
      end
      ST_READ: begin
        strb.select = 1'b1;
        strb.oeLow  = 1'b1;
        if (cntQ == CNT_W'(RD_CYC - 1)) begin
          strb.capture = 1'b1;
          ackD         = 1'b1;
          cntD         = '0;
          stateD       = ST_IDLE;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_WPULSE: begin
        strb.select = 1'b1;
        strb.weLow  = 1'b1;
        strb.drive  = 1'b1;
        if (cntQ == CNT_W'(WP_CYC - 1)) begin
          cntD   = '0;
          stateD = ST_WREC;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_WREC: begin
        strb.select = 1'b1;
        strb.drive  = (cntQ == '0);
        if (cntQ == CNT_W'(REC_CYC - 1)) begin
          ackD   = 1'b1;
          cntD   = '0;
          stateD = ST_IDLE;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      ackQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      ackQ   <= ackD;
    end
  end

  // consecutive cycles with the read strobe released, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeRunQ <= TURN_W'(TURN_CYC);
    end else if (strb.oeLow) begin
      oeRunQ <= '0;
    end else if (!turnOk) begin
      oeRunQ <= oeRunQ + 1'b1;
    end
  end

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.drive |-> turnOk);

  assert_no_accept_on_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !strb.select);

endmodule

// File: rtl/asram_ctrl_datapath.sv
module asram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.load) begin
      addrQ  <= hostAddr;
      wdataQ <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (strb.capture) begin
      rdDataQ <= dqIn;
    end
  end

  assign memAddr = addrQ;
  assign dqOut   = wdataQ;
  assign dqOe    = strb.drive;
  assign rdData  = rdDataQ;

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.select && $past(strb.select)) |-> $stable(addrQ));

  assert_wdata_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe && $past(dqOe)) |-> $stable(wdataQ));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !strb.oeLow);

endmodule

// File: rtl/asram_seq_ctrl.sv
module asram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_RD_CYCLE    = 35,
  parameter int T_ADDR_ACC    = 35,
  parameter int T_OE_ACC      = 15,
  parameter int T_WR_CYCLE    = 35,
  parameter int T_WE_PULSE    = 20,
  parameter int T_SEL_TO_END  = 25,
  parameter int T_DATA_SETUP  = 15,
  parameter int T_OE_HZ       = 12,
  parameter int T_WE_HZ       = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memRdN,
  output logic              memWrN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn
);

  strobe_t strb;

  asram_ctrl_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_RD_CYCLE(T_RD_CYCLE), .T_ADDR_ACC(T_ADDR_ACC),
    .T_OE_ACC(T_OE_ACC), .T_WR_CYCLE(T_WR_CYCLE), .T_WE_PULSE(T_WE_PULSE),
    .T_SEL_TO_END(T_SEL_TO_END), .T_DATA_SETUP(T_DATA_SETUP),
    .T_OE_HZ(T_OE_HZ), .T_WE_HZ(T_WE_HZ)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .strb(strb), .ack(ack)
  );

  asram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(reqAddr), .hostWdata(reqWdata),
    .dqIn(dqIn), .memAddr(memAddr), .dqOut(dqOut), .dqOe(dqOe), .rdData(rdData)
  );

  assign memSelN = !strb.select;
  assign memSelP = strb.select;
  assign memRdN  = !strb.oeLow;
  assign memWrN  = !strb.weLow;

  assert_write_selected_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWrN |-> (!memSelN && memSelP && memRdN));

  assert_release_after_we_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe && memWrN) |=> !dqOe);

  assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWrN |-> dqOe);

endmodule

// File: tb/asram_seq_ctrl_tb.sv
module asram_seq_ctrl_tb;

  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ack;
  logic [7:0]  rdData;
  logic [12:0] memAddr;
  logic        memSelN, memSelP, memRdN, memWrN;
  logic [7:0]  dqOut;
  logic        dqOe;
  logic [7:0]  dqIn;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  asram_seq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ack(ack), .rdData(rdData),
    .memAddr(memAddr), .memSelN(memSelN), .memSelP(memSelP), .memRdN(memRdN),
    .memWrN(memWrN), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural RAM model with timing checks ----------------
  logic [7:0] memArr [int];
  bit   memDriveQ = 1'b0;
  logic [7:0] memDqQ = 8'h00;
  int selRun = 0, oeRun = 0, addrRun = 0, weRun = 0, dataRun = 0, tail = 0;
  bit prevSel = 1'b0, prevWeN = 1'b1, prevRdN = 1'b1, prevDqOe = 1'b0, prevMemDrive = 1'b0;
  logic [12:0] prevAddr = '0;
  logic [7:0]  prevDq = '0;
  int weLowNeg = 0, driveNeg = 0, rdLowNeg = 0;

  assign dqIn = memDriveQ ? memDqQ : (dqOe ? dqOut : 8'h00);

  always @(negedge clk) begin
    bit sel, drv, valid;
    if (!rstN) begin
      selRun = 0; oeRun = 0; addrRun = 0; weRun = 0; dataRun = 0; tail = 0;
      memDriveQ = 1'b0;
    end else begin
      sel = !memSelN && memSelP;
      // write ends: rising write strobe while selected
      if (sel && memWrN && !prevWeN) begin
        check(weRun * P >= 20, "R4 write pulse ns", weRun * P, 20);
        check(selRun * P >= 25, "R4 select before write end ns", selRun * P, 25);
        check(dataRun * P >= 15, "R5 data setup ns", dataRun * P, 15);
        check(dqOe && dqOut == prevDq, "R5 data hold", int'(dqOe), 1);
        memArr[int'(memAddr)] = dqOut;
      end
      if (!sel && prevSel)
        check(selRun * P >= 35, "R2/R5 selected cycle ns", selRun * P, 35);
      // update running counters
      selRun  = sel ? selRun + 1 : 0;
      oeRun   = (sel && !memRdN) ? oeRun + 1 : 0;
      addrRun = (memAddr == prevAddr) ? addrRun + 1 : 1;
      weRun   = (sel && !memWrN) ? weRun + 1 : 0;
      dataRun = dqOe ? ((prevDqOe && dqOut == prevDq) ? dataRun + 1 : 1) : 0;
      drv   = sel && !memRdN && memWrN;
      valid = (selRun * P >= 35) && (oeRun * P >= 15) && (addrRun * P >= 35);
      if (prevMemDrive && !drv) tail = (!memWrN) ? 4 : 3;
      else if (tail > 0) tail = tail - 1;
      memDriveQ = drv || (tail > 0);
      memDqQ = (drv && valid) ? (memArr.exists(int'(memAddr)) ? memArr[int'(memAddr)] : 8'h00)
                              : 8'hEE;
      if (dqOe && memDriveQ) check(1'b0, "R6 bus contention", 1, 0);
      if (!memWrN) weLowNeg++;
      if (dqOe) driveNeg++;
      if (!memRdN) rdLowNeg++;
      prevSel = sel; prevWeN = memWrN; prevRdN = memRdN; prevDqOe = dqOe;
      prevAddr = memAddr; prevDq = dqOut; prevMemDrive = drv;
    end
  end

  // ---------------- host access ----------------
  task automatic access(input bit wr, input logic [12:0] a, input logic [7:0] d,
                        output logic [7:0] q, output int lat);
    @(negedge clk);
    weLowNeg = 0; driveNeg = 0; rdLowNeg = 0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 200);
    q = rdData;
    reqValid = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(memSelN == 1'b1 && memSelP == 1'b0, "R1 deselected in reset", int'(memSelP), 0);
    check(memRdN == 1'b1 && memWrN == 1'b1, "R1 strobes high in reset", int'(memWrN), 1);
    check(dqOe == 1'b0 && ack == 1'b0, "R1 no drive no ack in reset", int'(dqOe), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(memSelN == 1'b1 && dqOe == 1'b0 && ack == 1'b0, "R1 idle after reset", int'(dqOe), 0);
  endtask

  task automatic write_read(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] q;
    int lat;
    access(1'b1, a, d, q, lat);
    check(weLowNeg == 7, "R4 write strobe cycles", weLowNeg, 7);
    check(driveNeg == 8, "R5 drive cycles", driveNeg, 8);
    @(negedge clk);
    check(dqOe == 1'b0 && memSelN == 1'b1, "R5 released after write", int'(dqOe), 0);
    access(1'b0, a, 8'h00, q, lat);
    check(rdLowNeg == 9, "R2 read strobe cycles", rdLowNeg, 9);
    check(lat == 10, "R2 read latency", lat, 10);
    check(q == d, "R3 read data", int'(q), int'(d));
  endtask

  task automatic test_patterns();
    write_read(13'd3, 8'hA5);
    write_read(13'd4, 8'h5A);
    write_read(13'd5, 8'h00);
    write_read(13'd6, 8'hFF);
  endtask

  task automatic test_addr_edges();
    logic [7:0] q;
    int lat;
    access(1'b1, 13'd0, 8'h3C, q, lat);
    access(1'b1, 13'd8191, 8'hC3, q, lat);
    access(1'b0, 13'd0, 8'h00, q, lat);
    check(q == 8'h3C, "R8 address 0 data", int'(q), 8'h3C);
    access(1'b0, 13'd8191, 8'h00, q, lat);
    check(q == 8'hC3, "R8 address 8191 data", int'(q), 8'hC3);
    @(negedge clk);
    check(rdData == 8'hC3, "R3 read data held", int'(rdData), 8'hC3);
  endtask

  task automatic test_write_after_read();
    logic [7:0] q;
    int lat;
    access(1'b0, 13'd4, 8'h00, q, lat);
    check(q == 8'h5A, "R3 read before turnaround", int'(q), 8'h5A);
    access(1'b1, 13'd4, 8'h96, q, lat);
    check(lat == 13, "R6 turnaround wait in write latency", lat, 13);
    access(1'b0, 13'd4, 8'h00, q, lat);
    check(q == 8'h96, "R6 data after turnaround write", int'(q), 8'h96);
  endtask

  task automatic test_ack_pulse();
    logic [7:0] q;
    int lat;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 13'd6;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 200);
    check(rdData == 8'hFF, "R3 read in ack test", int'(rdData), 8'hFF);
    // request still high across the ack cycle edge
    @(negedge clk);
    check(ack == 1'b0, "R7 ack one cycle", int'(ack), 0);
    check(memSelN == 1'b1, "R7 no accept during ack", int'(memSelN), 1);
    reqValid = 1'b0;
    @(negedge clk);
    access(1'b1, 13'd7, 8'h11, q, lat);
    @(negedge clk);
    check(ack == 1'b0, "R7 write ack one cycle", int'(ack), 0);
  endtask

  initial begin
    test_reset();
    test_patterns();
    test_addr_edges();
    test_write_after_read();
    test_ack_pulse();
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule